// File: doc/BRIEF.md
# Multi-Channel Lock Attempt Sequencer

This block decides which of sixteen receive channels may run a clock-and-data lock attempt at any moment. Every channel reports whether a signal is present, whether it wants to lock, and whether its current attempt ended in lock or in failure. The block hands out lock-attempt grants one channel at a time. It holds each grant until the attempt ends, and it keeps a count of the attempts that are in flight.

Two kinds of configuration gate the grants. A per-channel permission mask is spread over two 8-bit registers, and a clear bit keeps its channel from ever being granted. A concurrency cap register sets how many channels may hold a grant at once. Among the waiting channels that are eligible, the block serves them in round-robin order, so none of them starves. The lock acquisition itself happens outside the block. Configuration is loaded through a simple write-only port.

Top module: `lock_attempt_seq`

## Requirements
- R1: After reset no grant is held, the in-flight count is 0, all sixteen permission bits are set and the cap register holds 0.
- R2: A new grant goes only to a channel that, in the cycle before the grant appears, had both its request and its signal-present input high and held no grant.
- R3: A write to address 0 loads the permission bits of channels 0 to 7, and a write to address 1 loads those of channels 8 to 15, with data bit n standing for the channel at offset n. A channel whose permission bit is 0 never receives a new grant.
- R4: A write to address 2 loads the concurrency cap. A value of 0 means no cap, and any value above 16 acts as 16.
- R5: A new grant is issued only when the number of kept grants is below the effective cap. Lowering the cap below the current count keeps the existing grants and blocks new ones.
- R6: At most one new grant is issued per cycle. The search starts at the channel after the last one granted and wraps from 15 to 0. After reset the search starts at channel 0.
- R7: A grant stays high until its channel reports locked, reports failed, or drops signal-present. It falls at the next clock edge, and that channel cannot be granted again at the same edge.
- R8: `inflight_cnt` always equals the number of grant bits that are set, and it changes at the same edge as the grants.
- R9: A write to address 3 changes neither the mask nor the cap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 mask low, 1 mask high, 2 cap |
| cfg_wdata | input | 8 | Write data |
| sig_present | input | 16 | Per-channel signal present |
| lock_req | input | 16 | Per-channel wish to attempt lock |
| lock_done | input | 16 | Per-channel attempt ended locked |
| lock_fail | input | 16 | Per-channel attempt ended failed |
| grant | output | 16 | Per-channel lock-attempt grant |
| inflight_cnt | output | 5 | Number of grants held |

## Verification
The bench drives a permission mask that is split across the two halves. A design that swaps the halves or shifts the bits would grant a masked channel. The bench lowers the cap below the in-flight count and checks that the held grants survive while no new grant appears. It also writes caps of 0 and 200, which a design without the unlimited or saturating decode would read as zero room or as a small wrapped value. The bench checks release by locked, by failed and by signal loss, checks the round-robin wrap from 15 to 0, and checks that a released channel is not granted again at the same edge. A wrong release path would leave grants stuck or leave the count off by one.

// File: rtl/lockseq_pkg.sv
package lockseq_pkg;

   // Effective concurrency cap: zero or anything past the channel count means "all channels".
   function automatic int eff_limit(input int lim, input int nch);
      return (lim == 0 || lim > nch) ? nch : lim;
   endfunction

endpackage

// File: rtl/lockseq_cfg.sv
module lockseq_cfg #(
   parameter int NCH    = 16,
   parameter int CFG_W  = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CFG_W-1:0]  wdata,
   output logic [NCH-1:0]    mask,
   output logic [CFG_W-1:0]  lim
);
   localparam int NMREG = NCH / CFG_W;

   // one permission slice per register, slice k covers channels k*CFG_W upward
   for (genvar k = 0; k < NMREG; k++) begin : g_slice
      logic [CFG_W-1:0] slice_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                         slice_q <= '1;
         else if (we && addr == ADDR_W'(k))                  slice_q <= wdata;
      end
      assign mask[k*CFG_W +: CFG_W] = slice_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             lim <= '0;
      else if (we && addr == ADDR_W'(NMREG))  lim <= wdata;
   end
endmodule

// File: rtl/lockseq_rr.sv
module lockseq_rr #(
   parameter int NCH   = 16,
   parameter int IDX_W = 4
) (
   input  logic [NCH-1:0]   req,
   input  logic [IDX_W-1:0] last,
   output logic             valid,
   output logic [IDX_W-1:0] idx
);
   // first requester strictly after 'last', wrapping round
   always_comb begin
      valid = 1'b0;
      idx   = '0;
      for (int k = 1; k <= NCH; k++) begin
         int c;
         c = (int'(last) + k) % NCH;
         if (!valid && req[c]) begin
            valid = 1'b1;
            idx   = IDX_W'(c);
         end
      end
   end
endmodule

// File: rtl/lock_attempt_seq.sv
module lock_attempt_seq #(
   parameter  int NCH    = 16,
   parameter  int CFG_W  = 8,
   localparam int NMREG  = NCH / CFG_W,
   localparam int ADDR_W = $clog2(NMREG + 2),
   localparam int CNT_W  = $clog2(NCH + 1),
   localparam int IDX_W  = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic [NCH-1:0]    sig_present,
   input  logic [NCH-1:0]    lock_req,
   input  logic [NCH-1:0]    lock_done,
   input  logic [NCH-1:0]    lock_fail,
   output logic [NCH-1:0]    grant,
   output logic [CNT_W-1:0]  inflight_cnt
);
   if (NCH < 2) begin : g_bad_nch
      $error("lock_attempt_seq: NCH must be at least 2");
   end
   if (NCH % CFG_W != 0) begin : g_bad_split
      $error("lock_attempt_seq: NCH must be a multiple of CFG_W");
   end
   if (CFG_W < CNT_W) begin : g_bad_cfgw
      $error("lock_attempt_seq: CFG_W too narrow for the cap");
   end

   logic [NCH-1:0]   mask_w;
   logic [CFG_W-1:0] lim_w;
   logic [NCH-1:0]   grant_q, fin, kept, elig, new_oh;
   logic [CNT_W-1:0] cnt_q, kept_n, eff_lim;
   logic [IDX_W-1:0] last_q, pick_idx;
   logic             pick_ok, room, issue;

   lockseq_cfg #(.NCH(NCH), .CFG_W(CFG_W), .ADDR_W(ADDR_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .mask(mask_w), .lim(lim_w)
   );

   // per-channel end of attempt: locked, failed or signal gone
   for (genvar g = 0; g < NCH; g++) begin : g_fin
      assign fin[g] = grant_q[g] & (lock_done[g] | lock_fail[g] | ~sig_present[g]);
   end

   assign kept = grant_q & ~fin;
   assign elig = lock_req & sig_present & mask_w & ~grant_q;

   always_comb begin
      kept_n = '0;
      for (int i = 0; i < NCH; i++) kept_n = kept_n + CNT_W'(kept[i]);
   end

   assign eff_lim = CNT_W'(lockseq_pkg::eff_limit(int'(lim_w), NCH));
   assign room    = kept_n < eff_lim;

   lockseq_rr #(.NCH(NCH), .IDX_W(IDX_W)) u_rr (
      .req(elig), .last(last_q), .valid(pick_ok), .idx(pick_idx)
   );

   assign issue  = pick_ok & room;
   assign new_oh = issue ? (NCH'(1) << pick_idx) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_q <= '0;
         cnt_q   <= '0;
         last_q  <= IDX_W'(NCH - 1);
      end else begin
         grant_q <= kept | new_oh;
         cnt_q   <= kept_n + CNT_W'(issue);
         if (issue) last_q <= pick_idx;
      end
   end

   assign grant        = grant_q;
   assign inflight_cnt = cnt_q;
endmodule

// File: rtl/lockseq_chk.sv
module lockseq_chk #(
   parameter  int NCH   = 16,
   parameter  int CFG_W = 8,
   localparam int CNT_W = $clog2(NCH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NCH-1:0]   grant,
   input logic [CNT_W-1:0] inflight_cnt,
   input logic [NCH-1:0]   mask,
   input logic [CFG_W-1:0] lim,
   input logic [NCH-1:0]   sig_present,
   input logic [NCH-1:0]   lock_req,
   input logic [NCH-1:0]   lock_done,
   input logic [NCH-1:0]   lock_fail
);
   int cap;
   always_comb cap = lockseq_pkg::eff_limit(int'(lim), NCH);

   p_new_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant & ~$past(grant)) & ~($past(lock_req) & $past(sig_present))) == '0);

   p_new_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant & ~$past(grant)) & ~$past(mask)) == '0);

   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(grant & ~$past(grant))) |-> ($countones(grant) <= $past(cap)));

   p_one_new_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(grant & ~$past(grant)) <= 1);

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(grant) & ~$past(lock_done | lock_fail | ~sig_present) & ~grant) == '0);

   p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(grant) & $past(lock_done | lock_fail | ~sig_present) & grant) == '0);

   p_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
      int'(inflight_cnt) == $countones(grant));
endmodule

bind lock_attempt_seq lockseq_chk #(.NCH(NCH), .CFG_W(CFG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .grant(grant), .inflight_cnt(inflight_cnt),
   .mask(mask_w), .lim(lim_w), .sig_present(sig_present), .lock_req(lock_req),
   .lock_done(lock_done), .lock_fail(lock_fail)
);

// File: tb/lock_attempt_seq_tb.sv
module lock_attempt_seq_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [15:0] sig = '0, req = '0, done = '0, fail = '0;
   logic [15:0] grant;
   logic [4:0]  inflight_cnt;

   int    n_checks = 0, n_fail = 0;
   string tag = "R1";

   // behavioural reference state
   logic [15:0] m_grant, m_mask;
   int          m_last, m_lim, m_cnt;
   bit          m_ready = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   lock_attempt_seq u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .sig_present(sig), .lock_req(req),
      .lock_done(done), .lock_fail(fail), .grant(grant), .inflight_cnt(inflight_cnt)
   );

   task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
      end
   endtask

   // reference model: queue of waiting channels in service order
   always @(posedge clk) begin
      logic [15:0] keep;
      int          waitq[$];
      int          cap;
      if (!rst_n) begin
         m_grant = '0; m_mask = 16'hFFFF; m_last = 15; m_lim = 0; m_cnt = 0;
         m_ready = 1;
      end else begin
         keep = m_grant;
         for (int i = 0; i < 16; i++)
            if (m_grant[i] && (done[i] || fail[i] || !sig[i])) keep[i] = 1'b0;
         cap = (m_lim == 0 || m_lim > 16) ? 16 : m_lim;
         waitq.delete();
         for (int k = 1; k <= 16; k++) begin
            int c;
            c = (m_last + k) % 16;
            if (req[c] && sig[c] && m_mask[c] && !m_grant[c]) waitq.push_back(c);
         end
         if (waitq.size() > 0 && $countones(keep) < cap) begin
            keep[waitq[0]] = 1'b1;
            m_last = waitq[0];
         end
         m_grant = keep;
         m_cnt   = $countones(keep);
         if (cfg_we) begin
            case (cfg_addr)
               2'd0: m_mask[7:0]  = cfg_wdata;
               2'd1: m_mask[15:8] = cfg_wdata;
               2'd2: m_lim        = int'(cfg_wdata);
               default: ;
            endcase
         end
      end
   end

   // compare every cycle away from the active edge
   always @(negedge clk) begin
      if (rst_n && m_ready)
         chk({tag, " model"}, {11'd0, inflight_cnt, grant}, {11'd0, m_cnt[4:0], m_grant});
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic release_all();
      @(negedge clk);
      req = '0; fail = 16'hFFFF;
      @(negedge clk);
      fail = '0;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      chk("R1 reset grant", {16'd0, grant}, 32'h0);
      chk("R1 reset count", {27'd0, inflight_cnt}, 32'h0);
      sig = 16'hFFFF; req = 16'hFFFF;

      tag = "R6";
      cyc(1); chk("R6/R1 first grant ch0", {16'd0, grant}, 32'h0001);
      cyc(1); chk("R6 second grant ch1", {16'd0, grant}, 32'h0003);
      cyc(14);
      chk("R6 all granted", {16'd0, grant}, 32'hFFFF);
      chk("R8 count 16", {27'd0, inflight_cnt}, 32'd16);

      tag = "R7";
      done = 16'h0010;
      cyc(1); done = '0;
      chk("R7 locked releases ch4", {16'd0, grant}, 32'hFFEF);
      chk("R8 count after release", {27'd0, inflight_cnt}, 32'd15);
      cyc(1); chk("R7 ch4 granted again later", {16'd0, grant}, 32'hFFFF);
      sig = 16'hFDFF;
      cyc(1); chk("R7 signal loss releases ch9", {16'd0, grant}, 32'hFDFF);
      cyc(2); chk("R2 no grant without signal", {16'd0, grant}, 32'hFDFF);
      sig = 16'hFFFF;
      cyc(1); chk("R7 ch9 back", {16'd0, grant}, 32'hFFFF);
      release_all();
      chk("R7 failed releases all", {16'd0, grant}, 32'h0);

      tag = "R4";
      cfg_write(2'd2, 8'd3);
      req = 16'hFFFF;
      cyc(5);
      chk("R4 cap 3 count", {27'd0, inflight_cnt}, 32'd3);
      chk("R6 wrap after ch9", {16'd0, grant}, 32'h1C00);
      cfg_write(2'd2, 8'd200);
      cyc(16);
      chk("R4 cap 200 saturates to 16", {16'd0, grant}, 32'hFFFF);

      tag = "R5";
      cfg_write(2'd2, 8'd2);
      cyc(3);
      chk("R5 lowered cap keeps grants", {16'd0, grant}, 32'hFFFF);
      done = 16'h0001;
      cyc(1); done = '0;
      cyc(2);
      chk("R5 no new grant above cap", {16'd0, grant}, 32'hFFFE);
      chk("R5 count 15", {27'd0, inflight_cnt}, 32'd15);
      release_all();

      tag = "R3";
      cfg_write(2'd2, 8'd0);
      cfg_write(2'd0, 8'h0F);
      cfg_write(2'd1, 8'h80);
      req = 16'hFFFF;
      cyc(8);
      chk("R3 split mask honoured", {16'd0, grant}, 32'h800F);

      tag = "R9";
      cfg_write(2'd3, 8'h00);
      release_all();
      req = 16'hFFFF;
      cyc(8);
      chk("R9 address 3 ignored", {16'd0, grant}, 32'h800F);

      tag = "R2";
      cfg_write(2'd0, 8'hFF);
      cfg_write(2'd1, 8'hFF);
      release_all();
      sig = 16'h00FF; req = 16'hFF00;
      cyc(5);
      chk("R2 request without signal", {16'd0, grant}, 32'h0);
      req = 16'h0F0F;
      cyc(10);
      chk("R2 only signalled requesters", {16'd0, grant}, 32'h000F);

      tag = "R5 random";
      for (int n = 0; n < 4000; n++) begin
         @(negedge clk);
         sig  = ~(16'($urandom) & 16'($urandom) & 16'($urandom));
         req  = 16'($urandom);
         done = 16'($urandom) & 16'($urandom) & 16'($urandom);
         fail = 16'($urandom) & 16'($urandom) & 16'($urandom) & 16'($urandom);
         cfg_we = 1'b0;
         if (n % 37 == 0) begin
            cfg_we   = 1'b1;
            cfg_addr = 2'($urandom % 4);
            cfg_wdata = (cfg_addr == 2'd2) ? 8'($urandom % 20) : 8'($urandom | 32'h11);
         end
      end
      @(negedge clk);
      cfg_we = 1'b0;
      cyc(2);
      summary();
      $finish;
   end
endmodule